// File: doc/BRIEF.md
# Cascade Repeater Serial Bus Interface

This block links several repeater chips so that together they act as one hub. The chips share a serial expansion bus that has three lines: a data line carrying NRZ bits, a framing enable and a bus clock. When one of its own ports starts receiving, a chip asks for the bus. It takes the bus only if the acknowledge chain grants it and no other chip is already framing. While it holds the bus, it drives all three lines, with the bus clock running at half the system clock rate. It launches each bit when the bus clock falls. At all other times the three lines are inputs, and the block captures the data line on each rising edge of the incoming bus clock while the incoming enable is high.

The block also drives two shared active-low status lines as open-drain pull-downs and senses their wired levels. One line reports activity on any port of any chip. The other reports a transmit collision, or collisions on more than one local port at the same moment. Each tristate or open-drain output is modelled as a value plus a separate enable. The acknowledge output passes the acknowledge input down the chain unless this chip currently owns the bus.

Top module: `cascade_bus_if`

## Requirements
- R1: Reset behaviour. While reset is held and in the first cycle after it, the block drives none of the data, enable and clock lines (all three output enables are 0). It pulls neither status line (both drive enables are 0), and its receive strobe is 0.
- R2: Bus request. The block takes the bus on a clock edge only if three inputs were sampled at that edge: local receive activity is 1, the acknowledge input is 1, and the incoming enable is 0. If any one of them is missing, the output enables stay 0.
- R3: Driving state. While the block owns the bus, all three output enables are 1 and the enable output is 1. The bus clock output starts low in the first owned cycle and then inverts on every system clock cycle.
- R4: Bit launch. The first bit appears on the data output in the first owned cycle, while the bus clock is low. Each following bit is taken from the local data input, and the data output changes only in the cycle in which the bus clock output falls.
- R5: Release. When local receive activity is 0 at the edge that ends a clock-high phase, that edge releases the bus. All output enables return to 0 and the bus clock output returns to 0 in the same cycle. A request that drops during a clock-low phase therefore still completes that bus clock period.
- R6: Acknowledge chain. The acknowledge output equals the acknowledge input whenever the block does not own the bus, and it is 0 while the block owns the bus. This path is combinational.
- R7: Capture. When the block does not own the bus and the incoming enable is 1, a change of the incoming bus clock from 0 to 1 makes the block sample the data line. The sampled bit appears on the received-data output, with the receive strobe set for exactly one cycle, in the cycle after the edge at which the high clock level is first seen.
- R8: Capture gating. A rising incoming bus clock has no effect on the received-data output or the receive strobe while the incoming enable is 0, or while the block owns the bus.
- R9: Activity pull-down. The activity drive enable is 1 in the cycle after an edge at which local receive activity or any port collision bit was 1. Otherwise it is 0.
- R10: Collision pull-down. The collision drive enable is 1 in the cycle after an edge at which the transmit-collision input was 1, or at which two or more port collision bits were 1. A single port collision bit alone leaves it at 0.
- R11: Sensing. The any-activity output is the inverse of the sensed activity line, and the other-collision output is the inverse of the sensed collision line. Each follows its line one cycle after the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| localRxActive | input | 1 | A local port is receiving; requests the bus |
| localTxData | input | 1 | Next NRZ bit to launch while owning the bus |
| portColl | input | NumPorts | Per-port collision flags |
| txColl | input | 1 | Transmit collision detected |
| ackIn | input | 1 | Acknowledge from the upstream chip |
| ackOut | output | 1 | Acknowledge to the downstream chip |
| busDataIn | input | 1 | Sensed bus data line |
| busDataOut | output | 1 | Driven bus data value |
| busDataOe | output | 1 | Output enable for the data line |
| busEnIn | input | 1 | Sensed bus framing enable |
| busEnOut | output | 1 | Driven framing enable value |
| busEnOe | output | 1 | Output enable for the framing line |
| busClkIn | input | 1 | Sensed bus clock |
| busClkOut | output | 1 | Driven bus clock value |
| busClkOe | output | 1 | Output enable for the bus clock |
| actNIn | input | 1 | Sensed wired activity line, active low |
| actNDrive | output | 1 | Pull-down enable for the activity line |
| collNIn | input | 1 | Sensed wired collision line, active low |
| collNDrive | output | 1 | Pull-down enable for the collision line |
| rxData | output | 1 | Last bit captured from the bus |
| rxValid | output | 1 | One-cycle strobe for a newly captured bit |
| anyActive | output | 1 | Some chip reports activity |
| otherColl | output | 1 | Some chip reports a multi-port or transmit collision |

## Verification
Most results are registered and are due one cycle after the edge that samples their cause. This covers bus ownership, the first launched bit, every bus clock level, the release, the captured bit and its strobe, and the two status pull-downs and sensed flags. The one exception is the acknowledge output, which follows in the same cycle. The bench sets its stimulus at the falling system clock edge, lets exactly one rising edge pass per step, and checks at the next falling edge. A bus clock period takes two such steps. Within it, the bench checks that each bit is still present during the clock-high phase, and it feeds the next bit only while the clock is low.

// File: rtl/cbus_pkg.sv
package cbus_pkg;
  typedef struct packed {
    logic drive;   // bus owned this cycle
    logic clkLvl;  // driven bus clock level
    logic launch;  // load next bit at this edge
  } busStrobeT;
endpackage

// File: rtl/cbus_ctrl.sv
module cbus_ctrl
  import cbus_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      localRxActive,
  input  logic      ackIn,
  input  logic      busEnIn,
  output busStrobeT strobe
);
  typedef enum logic {ST_IDLE, ST_DRIVE} ctrlStateT;

  ctrlStateT state;
  logic      phaseHigh;
  logic      grant;
  logic      endPeriod;

  assign grant     = (state == ST_IDLE) && localRxActive && ackIn && !busEnIn;
  assign endPeriod = (state == ST_DRIVE) && phaseHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      phaseHigh <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          phaseHigh <= 1'b0;
          if (grant) state <= ST_DRIVE;
        end
        default: begin
          if (endPeriod && !localRxActive) begin
            state     <= ST_IDLE;
            phaseHigh <= 1'b0;
          end else begin
            phaseHigh <= !phaseHigh;
          end
        end
      endcase
    end
  end

  always_comb begin
    strobe.drive  = (state == ST_DRIVE);
    strobe.clkLvl = phaseHigh;
    strobe.launch = grant || (endPeriod && localRxActive);
  end
endmodule

// File: rtl/cbus_datapath.sv
module cbus_datapath
  import cbus_pkg::*;
#(
  parameter int NumPorts = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  busStrobeT           strobe,
  input  logic                localRxActive,
  input  logic                localTxData,
  input  logic [NumPorts-1:0] portColl,
  input  logic                txColl,
  input  logic                busDataIn,
  input  logic                busEnIn,
  input  logic                busClkIn,
  input  logic                actNIn,
  input  logic                collNIn,
  output logic                busDataOut,
  output logic                rxData,
  output logic                rxValid,
  output logic                actNDrive,
  output logic                collNDrive,
  output logic                anyActive,
  output logic                otherColl
);
  logic                txBit;
  logic                clkPrev;
  logic                clkRise;
  logic                multiColl;
  logic [NumPorts-1:0] collLowerCleared;

  assign clkRise          = busClkIn && !clkPrev;
  assign collLowerCleared = portColl & (portColl - NumPorts'(1));
  assign multiColl        = |collLowerCleared;

  // launch side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              txBit <= 1'b0;
    else if (strobe.launch) txBit <= localTxData;
  end
  assign busDataOut = txBit;

  // capture side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev <= 1'b0;
      rxData  <= 1'b0;
      rxValid <= 1'b0;
    end else begin
      clkPrev <= busClkIn;
      rxValid <= 1'b0;
      if (clkRise && busEnIn && !strobe.drive) begin
        rxData  <= busDataIn;
        rxValid <= 1'b1;
      end
    end
  end

  // wired status lines
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actNDrive  <= 1'b0;
      collNDrive <= 1'b0;
      anyActive  <= 1'b0;
      otherColl  <= 1'b0;
    end else begin
      actNDrive  <= localRxActive || (|portColl);
      collNDrive <= txColl || multiColl;
      anyActive  <= !actNIn;
      otherColl  <= !collNIn;
    end
  end
endmodule

// File: rtl/cascade_bus_if.sv
module cascade_bus_if
  import cbus_pkg::*;
#(
  parameter int NumPorts = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                localRxActive,
  input  logic                localTxData,
  input  logic [NumPorts-1:0] portColl,
  input  logic                txColl,
  input  logic                ackIn,
  output logic                ackOut,
  input  logic                busDataIn,
  output logic                busDataOut,
  output logic                busDataOe,
  input  logic                busEnIn,
  output logic                busEnOut,
  output logic                busEnOe,
  input  logic                busClkIn,
  output logic                busClkOut,
  output logic                busClkOe,
  input  logic                actNIn,
  output logic                actNDrive,
  input  logic                collNIn,
  output logic                collNDrive,
  output logic                rxData,
  output logic                rxValid,
  output logic                anyActive,
  output logic                otherColl
);
  busStrobeT strobe;

  cbus_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .localRxActive(localRxActive),
    .ackIn(ackIn), .busEnIn(busEnIn), .strobe(strobe)
  );

  cbus_datapath #(.NumPorts(NumPorts)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .localRxActive(localRxActive), .localTxData(localTxData),
    .portColl(portColl), .txColl(txColl),
    .busDataIn(busDataIn), .busEnIn(busEnIn), .busClkIn(busClkIn),
    .actNIn(actNIn), .collNIn(collNIn),
    .busDataOut(busDataOut), .rxData(rxData), .rxValid(rxValid),
    .actNDrive(actNDrive), .collNDrive(collNDrive),
    .anyActive(anyActive), .otherColl(otherColl)
  );

  assign busDataOe = strobe.drive;
  assign busEnOe   = strobe.drive;
  assign busClkOe  = strobe.drive;
  assign busEnOut  = strobe.drive;
  assign busClkOut = strobe.clkLvl;
  assign ackOut    = ackIn && !strobe.drive;
endmodule

// File: rtl/cbus_checker.sv
module cbus_checker #(
  parameter int NumPorts = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                localRxActive,
  input logic [NumPorts-1:0] portColl,
  input logic                txColl,
  input logic                ackIn,
  input logic                ackOut,
  input logic                busEnIn,
  input logic                busEnOe,
  input logic                busDataOut,
  input logic                busClkOut,
  input logic                rxValid,
  input logic                collNDrive
);
  p_grant_needs_ack_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busEnOe) |-> ($past(ackIn) && $past(localRxActive) && !$past(busEnIn)));

  p_clk_toggles_r3: assert property (@(posedge clk) disable iff (!rstN)
    busEnOe |=> (!busEnOe || (busClkOut != $past(busClkOut))));

  p_data_on_fall_r4: assert property (@(posedge clk) disable iff (!rstN)
    busEnOe |=> (!busEnOe || $stable(busDataOut) || $fell(busClkOut)));

  p_release_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busEnOe) |-> (!busClkOut && !$past(localRxActive)));

  p_ack_blocked_r6: assert property (@(posedge clk) disable iff (!rstN)
    busEnOe |-> !ackOut);

  p_strobe_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  p_no_self_capture_r8: assert property (@(posedge clk) disable iff (!rstN)
    busEnOe |=> !rxValid);

  p_single_coll_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(portColl) <= 1 && !txColl) |=> !collNDrive);
endmodule

bind cascade_bus_if cbus_checker #(.NumPorts(NumPorts)) u_chk (
  .clk(clk), .rstN(rstN), .localRxActive(localRxActive),
  .portColl(portColl), .txColl(txColl), .ackIn(ackIn), .ackOut(ackOut),
  .busEnIn(busEnIn), .busEnOe(busEnOe), .busDataOut(busDataOut),
  .busClkOut(busClkOut), .rxValid(rxValid), .collNDrive(collNDrive)
);

// File: tb/cascade_bus_if_tb.sv
module cascade_bus_if_tb;
  localparam int NumPorts = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic localRxActive = 1'b0, localTxData = 1'b0, txColl = 1'b0;
  logic [NumPorts-1:0] portColl = '0;
  logic ackIn = 1'b0, busDataIn = 1'b0, busEnIn = 1'b0, busClkIn = 1'b0;
  logic actNIn = 1'b1, collNIn = 1'b1;
  logic ackOut, busDataOut, busDataOe, busEnOut, busEnOe, busClkOut, busClkOe;
  logic actNDrive, collNDrive, rxData, rxValid, anyActive, otherColl;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cascade_bus_if #(.NumPorts(NumPorts)) u_dut (
    .clk(clk), .rstN(rstN), .localRxActive(localRxActive),
    .localTxData(localTxData), .portColl(portColl), .txColl(txColl),
    .ackIn(ackIn), .ackOut(ackOut),
    .busDataIn(busDataIn), .busDataOut(busDataOut), .busDataOe(busDataOe),
    .busEnIn(busEnIn), .busEnOut(busEnOut), .busEnOe(busEnOe),
    .busClkIn(busClkIn), .busClkOut(busClkOut), .busClkOe(busClkOe),
    .actNIn(actNIn), .actNDrive(actNDrive), .collNIn(collNIn),
    .collNDrive(collNDrive), .rxData(rxData), .rxValid(rxValid),
    .anyActive(anyActive), .otherColl(otherColl)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic test_reset();
    @(negedge clk);
    ackIn = 1'b1;
    #1;
    check("R1 oe data", busDataOe, 0);
    check("R1 oe en", busEnOe, 0);
    check("R1 oe clk", busClkOe, 0);
    check("R1 rxValid", rxValid, 0);
    check("R1 act drive", actNDrive, 0);
    check("R1 coll drive", collNDrive, 0);
    rstN = 1'b1;
    step();
    check("R1 idle after reset", busEnOe, 0);
    check("R6 ack passes", ackOut, 1);
  endtask

  task automatic test_no_grant();
    localRxActive = 1'b1; ackIn = 1'b0; busEnIn = 1'b0;
    step();
    check("R2 no ack no grant", busEnOe, 0);
    check("R6 ack low passes", ackOut, 0);
    ackIn = 1'b1; busEnIn = 1'b1;
    step();
    check("R2 busy no grant", busEnOe, 0);
    localRxActive = 1'b0; busEnIn = 1'b0;
    step();
    check("R2 no request no grant", busEnOe, 0);
  endtask

  task automatic test_master_frame(input logic [7:0] bits, input int n);
    ackIn = 1'b1; busEnIn = 1'b0; localRxActive = 1'b1;
    localTxData = bits[0];
    step();
    for (int i = 0; i < n; i++) begin
      check("R3 owned oe", busDataOe & busEnOe & busClkOe & busEnOut, 1);
      check("R3 clk low phase", busClkOut, 0);
      check("R4 bit at low", busDataOut, bits[i]);
      check("R6 ack blocked", ackOut, 0);
      if (i + 1 < n) localTxData = bits[i+1];
      else begin
        localTxData = ~bits[i];
        localRxActive = 1'b0;
      end
      step();
      check("R3 clk high phase", busClkOut, 1);
      check("R4 bit held at high", busDataOut, bits[i]);
      check("R5 still owned", busEnOe, 1);
      step();
    end
    check("R5 released oe", busDataOe | busEnOe | busClkOe, 0);
    check("R5 clk low after release", busClkOut, 0);
    check("R6 ack restored", ackOut, 1);
  endtask

  task automatic test_capture();
    busEnIn = 1'b1; busClkIn = 1'b0; busDataIn = 1'b1;
    step();
    check("R7 no strobe before rise", rxValid, 0);
    busClkIn = 1'b1;
    step();
    check("R7 strobe", rxValid, 1);
    check("R7 data one", rxData, 1);
    busDataIn = 1'b0;
    step();
    check("R7 strobe one cycle", rxValid, 0);
    busClkIn = 1'b0;
    step();
    busClkIn = 1'b1;
    step();
    check("R7 strobe second", rxValid, 1);
    check("R7 data zero", rxData, 0);
    busClkIn = 1'b0;
    step();
  endtask

  task automatic test_capture_ignored();
    busEnIn = 1'b0; busDataIn = 1'b1; busClkIn = 1'b0;
    step();
    busClkIn = 1'b1;
    step();
    check("R8 enable low no strobe", rxValid, 0);
    check("R8 enable low data kept", rxData, 0);
    busClkIn = 1'b0;
    ackIn = 1'b1; localRxActive = 1'b1; localTxData = 1'b0;
    step();
    check("R8 owner setup", busEnOe, 1);
    busEnIn = 1'b1; busClkIn = 1'b1;
    step();
    check("R8 owner no strobe", rxValid, 0);
    check("R8 owner data kept", rxData, 0);
    localRxActive = 1'b0; busEnIn = 1'b0; busClkIn = 1'b0;
    step();
    step();
    check("R8 owner released", busEnOe, 0);
  endtask

  task automatic test_status();
    portColl = 8'b0000_0100;
    step();
    check("R9 act from single coll", actNDrive, 1);
    check("R10 single coll quiet", collNDrive, 0);
    portColl = 8'b1000_0010;
    step();
    check("R10 two colls", collNDrive, 1);
    portColl = '0; txColl = 1'b1;
    step();
    check("R10 tx coll", collNDrive, 1);
    check("R9 act idle", actNDrive, 0);
    txColl = 1'b0; localRxActive = 1'b1; ackIn = 1'b0;
    step();
    check("R9 act from rx", actNDrive, 1);
    check("R10 coll cleared", collNDrive, 0);
    localRxActive = 1'b0; actNIn = 1'b0; collNIn = 1'b1;
    step();
    check("R11 any active", anyActive, 1);
    check("R11 no other coll", otherColl, 0);
    actNIn = 1'b1; collNIn = 1'b0;
    step();
    check("R11 active cleared", anyActive, 0);
    check("R11 other coll", otherColl, 1);
    collNIn = 1'b1;
    step();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    step();
    step();
    test_reset();
    test_no_grant();
    test_master_frame(8'b0110_1101, 8);
    test_master_frame(8'b0000_0001, 1);
    test_capture();
    test_capture_ignored();
    test_status();
    summary();
  end
endmodule